// File: doc/BRIEF.md
# SIMD Lane Select and Lane Access Unit

This block holds one vector register of 64 lanes, each lane a 32-bit element, and performs the cross-lane operations of a wavefront ALU on it. Each lane number is the same as the thread id of the wavefront. There are three operations. A lane read copies one element of the held vector to a scalar result. A lane write stores a scalar word into one chosen element of the held vector. A masked select builds a new vector by taking, lane by lane, either the first or the second vector source, as a 64-bit condition mask directs.

The lane number comes from a 32-bit scalar word. Only its six low bits are used, so any value wraps onto a valid lane. The masked select takes its mask from one of two inputs. One is the implicit vector condition mask used by the compact instruction form. The other is an explicitly named scalar register pair used by the wide form. A single input picks between them. Results are registered and appear one cycle after the operation is issued. Lane writes take effect at the clock edge that accepts them.

Top module: `lane_xfer_unit`

## Requirements
- R1: While `rst_n` is low and after it rises, all 64 held lanes read as zero, `res_valid` is low, and `scalar_res` and `vector_res` are zero until an operation updates them.
- R2: `op_code` 2'b01 with `op_valid` high is a lane read: on the next cycle `scalar_res` equals held lane (`lane_idx_word` AND 63) and `res_valid` is high.
- R3: Bits 31..6 of `lane_idx_word` have no effect: two index words that share their six low bits select the same lane for both reads and writes.
- R4: `op_code` 2'b10 with `op_valid` high is a lane write: at that clock edge held lane (`lane_idx_word` AND 63) takes `scalar_data`, and every other held lane keeps its value.
- R5: `op_code` 2'b00 with `op_valid` high is a masked select: on the next cycle lane i of `vector_res` (bits 32i+31..32i) equals lane i of `vsrc_b` when mask bit i is 1 and lane i of `vsrc_a` when it is 0, and `res_valid` is high.
- R6: The masked select uses `vcc_mask` when `mask_src_explicit` is 0 and `pair_mask` when it is 1. The unused mask has no effect.
- R7: A lane read issued in the cycle right after a lane write to the same lane returns the newly written word.
- R8: `op_code` 2'b11, or any code with `op_valid` low, changes no held lane and neither result output, and `res_valid` is low on the next cycle.
- R9: A lane write leaves `scalar_res` and `vector_res` unchanged and gives `res_valid` low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 2 | 00 masked select, 01 lane read, 10 lane write, 11 no-op |
| lane_idx_word | input | 32 | Scalar whose six low bits give the lane |
| scalar_data | input | 32 | Word stored by a lane write |
| mask_src_explicit | input | 1 | 0 selects `vcc_mask`, 1 selects `pair_mask` |
| vcc_mask | input | 64 | Implicit vector condition mask |
| pair_mask | input | 64 | Explicit scalar register pair mask |
| vsrc_a | input | 2048 | First vector source, lane i in bits 32i+31..32i |
| vsrc_b | input | 2048 | Second vector source, same lane layout |
| res_valid | output | 1 | A read or select result was produced last cycle |
| scalar_res | output | 32 | Last lane read result |
| vector_res | output | 2048 | Last masked select result |

## Verification
The lane read and lane write paths are driven from a table. The table uses index words with set upper bits, lane 0 rewritten through a wrapped index, both end lanes and a back-to-back write then read of one lane. A sweep of all 64 lanes then shows that no neighbouring lane was touched. The masked select is tried with all-zero and all-ones masks, which show the two sources apart, and with an alternating mask, which catches swapped or shifted lanes. A mask with only the two end bits set checks the lane ordering at both ends. The same nibble-striped mask is applied first through the implicit input and then through the explicit input, with the other input holding the inverse pattern, so that a wrong mask source is visible.

// File: rtl/lane_xfer_pkg.sv
// Package: lane_xfer_pkg
// Shared constants and the operation code type for the lane access unit.
// Assumes the lane count is a power of two, so that masking an index with
// (lane count - 1) is the same as taking its low bits.
package lane_xfer_pkg;

    localparam int unsigned LANE_COUNT   = 64;
    localparam int unsigned LANE_ELEM_W  = 32;
    localparam int unsigned INDEX_WORD_W = 32;

    // Operation codes seen on op_code.
    typedef enum logic [1:0] {
        OP_MASK_SEL = 2'b00,
        OP_LANE_RD  = 2'b01,
        OP_LANE_WR  = 2'b10,
        OP_IDLE     = 2'b11
    } lane_op_e;

endpackage

// File: rtl/lane_index_decode.sv
// Module: lane_index_decode
// Turns a scalar index word into a lane number (the word's low bits, the
// same as AND with LANES-1) and a one-hot lane enable vector.
// Assumes LANES is a power of two and IDX_WORD_W is wider than log2(LANES).
module lane_index_decode #(
    parameter int unsigned LANES      = 64,
    parameter int unsigned IDX_WORD_W = 32,
    localparam int unsigned IDX_W     = $clog2(LANES)
) (
    input  logic [IDX_WORD_W-1:0] idx_word,
    output logic [IDX_W-1:0]      lane_num,
    output logic [LANES-1:0]      lane_onehot
);

    // Upper index bits are dropped on purpose. They are reduced here only so
    // that they count as read.
    logic idx_hi_unused;
    assign idx_hi_unused = ^idx_word[IDX_WORD_W-1:IDX_W];

    // Lane number is the masked index.
    assign lane_num = idx_word[IDX_W-1:0];

    // One comparator per lane forms the one-hot enable.
    for (genvar g = 0; g < LANES; g++) begin : g_hot
        assign lane_onehot[g] = (lane_num == IDX_W'(g));
    end

endmodule

// File: rtl/lane_store.sv
// Module: lane_store
// The held vector: LANES elements of ELEM_W bits with a per-lane write
// enable and one combinational read port.
// Assumes at most one lane is enabled for writing in a cycle.
module lane_store #(
    parameter int unsigned LANES  = 64,
    parameter int unsigned ELEM_W = 32,
    localparam int unsigned IDX_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [LANES-1:0]  wr_onehot,
    input  logic [ELEM_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_lane,
    output logic [ELEM_W-1:0] rd_data
);

    logic [ELEM_W-1:0] lane_q [LANES];

    // Clear every lane on reset; on a write, update only the enabled lane.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LANES; i++) begin
                lane_q[i] <= '0;
            end
        end else if (wr_en) begin
            for (int i = 0; i < LANES; i++) begin
                if (wr_onehot[i]) begin
                    lane_q[i] <= wr_data;
                end
            end
        end
    end

    // Read port: plain array select by lane number.
    assign rd_data = lane_q[rd_lane];

endmodule

// File: rtl/lane_mask_select.sv
// Module: lane_mask_select
// For each lane, passes the element of vec_b when its mask bit is set and
// the element of vec_a otherwise. Purely combinational.
// Assumes lane i sits in bits [i*ELEM_W +: ELEM_W] of each flat vector.
module lane_mask_select #(
    parameter int unsigned LANES  = 64,
    parameter int unsigned ELEM_W = 32,
    localparam int unsigned VEC_W = LANES * ELEM_W
) (
    input  logic [LANES-1:0] lane_mask,
    input  logic [VEC_W-1:0] vec_a,
    input  logic [VEC_W-1:0] vec_b,
    output logic [VEC_W-1:0] vec_y
);

    // One two-way mux per lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign vec_y[g*ELEM_W +: ELEM_W] = lane_mask[g] ? vec_b[g*ELEM_W +: ELEM_W]
                                                        : vec_a[g*ELEM_W +: ELEM_W];
    end

endmodule

// File: rtl/lane_xfer_unit.sv
// Module: lane_xfer_unit
// Lane access unit of a wavefront ALU. It holds one vector of LANES
// elements and performs lane read, lane write and masked select. Read and
// select results are registered and appear one cycle after issue, with
// res_valid high; a lane write changes the held vector at its clock edge.
// Assumes one operation per cycle and a synchronous active-low reset.
module lane_xfer_unit
    import lane_xfer_pkg::*;
#(
    parameter int unsigned LANES      = LANE_COUNT,
    parameter int unsigned ELEM_W     = LANE_ELEM_W,
    parameter int unsigned IDX_WORD_W = INDEX_WORD_W,
    localparam int unsigned IDX_W     = $clog2(LANES),
    localparam int unsigned VEC_W     = LANES * ELEM_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  op_valid,
    input  logic [1:0]            op_code,
    input  logic [IDX_WORD_W-1:0] lane_idx_word,
    input  logic [ELEM_W-1:0]     scalar_data,
    input  logic                  mask_src_explicit,
    input  logic [LANES-1:0]      vcc_mask,
    input  logic [LANES-1:0]      pair_mask,
    input  logic [VEC_W-1:0]      vsrc_a,
    input  logic [VEC_W-1:0]      vsrc_b,
    output logic                  res_valid,
    output logic [ELEM_W-1:0]     scalar_res,
    output logic [VEC_W-1:0]      vector_res
);

    logic              do_sel;
    logic              do_rd;
    logic              do_wr;
    logic [IDX_W-1:0]  lane_num;
    logic [LANES-1:0]  lane_onehot;
    logic [ELEM_W-1:0] lane_rd_data;
    logic [LANES-1:0]  sel_mask;
    logic [VEC_W-1:0]  sel_vec;
    logic              res_valid_q;
    logic [ELEM_W-1:0] scalar_q;
    logic [VEC_W-1:0]  vector_q;

    // Decode the operation strobes.
    always_comb begin
        do_sel = op_valid && (lane_op_e'(op_code) == OP_MASK_SEL);
        do_rd  = op_valid && (lane_op_e'(op_code) == OP_LANE_RD);
        do_wr  = op_valid && (lane_op_e'(op_code) == OP_LANE_WR);
    end

    // Pick the mask source: the implicit condition mask or the register pair.
    assign sel_mask = mask_src_explicit ? pair_mask : vcc_mask;

    lane_index_decode #(
        .LANES      (LANES),
        .IDX_WORD_W (IDX_WORD_W)
    ) idx_dec_i (
        .idx_word    (lane_idx_word),
        .lane_num    (lane_num),
        .lane_onehot (lane_onehot)
    );

    lane_store #(
        .LANES  (LANES),
        .ELEM_W (ELEM_W)
    ) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (do_wr),
        .wr_onehot (lane_onehot),
        .wr_data   (scalar_data),
        .rd_lane   (lane_num),
        .rd_data   (lane_rd_data)
    );

    lane_mask_select #(
        .LANES  (LANES),
        .ELEM_W (ELEM_W)
    ) msel_i (
        .lane_mask (sel_mask),
        .vec_a     (vsrc_a),
        .vec_b     (vsrc_b),
        .vec_y     (sel_vec)
    );

    // Result registers: each output updates only on its own operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid_q <= 1'b0;
            scalar_q    <= '0;
            vector_q    <= '0;
        end else begin
            res_valid_q <= do_sel || do_rd;
            if (do_rd) begin
                scalar_q <= lane_rd_data;
            end
            if (do_sel) begin
                vector_q <= sel_vec;
            end
        end
    end

    assign res_valid  = res_valid_q;
    assign scalar_res = scalar_q;
    assign vector_res = vector_q;

endmodule

// File: rtl/lane_xfer_chk.sv
// Module: lane_xfer_chk
// Property checker for lane_xfer_unit, attached through bind. Observes
// only the top-level ports.
module lane_xfer_chk #(
    parameter int unsigned LANES      = 64,
    parameter int unsigned ELEM_W     = 32,
    parameter int unsigned IDX_WORD_W = 32,
    localparam int unsigned IDX_W     = $clog2(LANES),
    localparam int unsigned VEC_W     = LANES * ELEM_W
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  op_valid,
    input logic [1:0]            op_code,
    input logic [IDX_WORD_W-1:0] lane_idx_word,
    input logic [ELEM_W-1:0]     scalar_data,
    input logic                  mask_src_explicit,
    input logic [LANES-1:0]      vcc_mask,
    input logic [LANES-1:0]      pair_mask,
    input logic [VEC_W-1:0]      vsrc_a,
    input logic [VEC_W-1:0]      vsrc_b,
    input logic                  res_valid,
    input logic [ELEM_W-1:0]     scalar_res,
    input logic [VEC_W-1:0]      vector_res
);

    logic             is_sel;
    logic             is_rd;
    logic             is_wr;
    logic [LANES-1:0] chk_mask;

    // Observation helpers taken from the ports.
    assign is_sel   = op_valid && (op_code == 2'b00);
    assign is_rd    = op_valid && (op_code == 2'b01);
    assign is_wr    = op_valid && (op_code == 2'b10);
    assign chk_mask = mask_src_explicit ? pair_mask : vcc_mask;

    AST_RD_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        is_rd |=> res_valid); // R2

    AST_SEL_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        is_sel |=> res_valid); // R5

    AST_QUIET_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !(is_sel || is_rd) |=> !res_valid); // R8

    AST_SCALAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !is_rd |=> $stable(scalar_res)); // R9

    AST_VECTOR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !is_sel |=> $stable(vector_res)); // R8

    AST_SEL_ALL_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        (is_sel && (chk_mask == {LANES{1'b1}})) |=> (vector_res == $past(vsrc_b))); // R5

    AST_SEL_ALL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (is_sel && (chk_mask == '0)) |=> (vector_res == $past(vsrc_a))); // R6

    AST_WRITE_THEN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(is_wr) && is_rd
         && (lane_idx_word[IDX_W-1:0] == $past(lane_idx_word[IDX_W-1:0])))
        |=> (scalar_res == $past(scalar_data, 2))); // R7

endmodule

bind lane_xfer_unit lane_xfer_chk #(
    .LANES      (LANES),
    .ELEM_W     (ELEM_W),
    .IDX_WORD_W (IDX_WORD_W)
) chk_i (
    .clk               (clk),
    .rst_n             (rst_n),
    .op_valid          (op_valid),
    .op_code           (op_code),
    .lane_idx_word     (lane_idx_word),
    .scalar_data       (scalar_data),
    .mask_src_explicit (mask_src_explicit),
    .vcc_mask          (vcc_mask),
    .pair_mask         (pair_mask),
    .vsrc_a            (vsrc_a),
    .vsrc_b            (vsrc_b),
    .res_valid         (res_valid),
    .scalar_res        (scalar_res),
    .vector_res        (vector_res)
);

// File: tb/lane_xfer_unit_tb_top.sv
`timescale 1ns/1ps
// Bench for lane_xfer_unit: table of lane writes and reads, then directed
// masked select, hold, no-op and reset tests.
module lane_xfer_unit_tb_top;

    localparam int LN = 64;
    localparam int EW = 32;
    localparam int VW = LN * EW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          op_valid;
    logic [1:0]    op_code;
    logic [31:0]   lane_idx_word;
    logic [31:0]   scalar_data;
    logic          mask_src_explicit;
    logic [LN-1:0] vcc_mask;
    logic [LN-1:0] pair_mask;
    logic [VW-1:0] vsrc_a;
    logic [VW-1:0] vsrc_b;
    logic          res_valid;
    logic [EW-1:0] scalar_res;
    logic [VW-1:0] vector_res;

    int          n_tests = 0;
    int          n_fail  = 0;
    logic [31:0] model [LN];

    always #4 clk = ~clk;

    lane_xfer_unit dut_i (
        .clk               (clk),
        .rst_n             (rst_n),
        .op_valid          (op_valid),
        .op_code           (op_code),
        .lane_idx_word     (lane_idx_word),
        .scalar_data       (scalar_data),
        .mask_src_explicit (mask_src_explicit),
        .vcc_mask          (vcc_mask),
        .pair_mask         (pair_mask),
        .vsrc_a            (vsrc_a),
        .vsrc_b            (vsrc_b),
        .res_valid         (res_valid),
        .scalar_res        (scalar_res),
        .vector_res        (vector_res)
    );

    // Entry: {op[1:0], index word, data, expected scalar result}
    localparam logic [97:0] TBL [11] = '{
        {2'b10, 32'h0000_0000, 32'h1111_0000, 32'h0},
        {2'b10, 32'h0000_003F, 32'hCAFE_0063, 32'h0},
        {2'b10, 32'hFFFF_FFC5, 32'h0505_A5A5, 32'h0},
        {2'b10, 32'h0000_0140, 32'h0000_0BAD, 32'h0},
        {2'b01, 32'h8000_0000, 32'h0,         32'h0000_0BAD},
        {2'b01, 32'h0000_007F, 32'h0,         32'hCAFE_0063},
        {2'b01, 32'h0000_0005, 32'h0,         32'h0505_A5A5},
        {2'b01, 32'h1234_5605, 32'h0,         32'h0505_A5A5},
        {2'b01, 32'h0000_0001, 32'h0,         32'h0},
        {2'b10, 32'h0000_001F, 32'h3131_3131, 32'h0},
        {2'b01, 32'h00C0_001F, 32'h0,         32'h3131_3131}
    };

    task automatic chk32(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chkvec(string tag, logic [VW-1:0] act, logic [VW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            for (int i = 0; i < LN; i++) begin
                if (act[i*EW +: EW] !== exp[i*EW +: EW]) begin
                    $display("FAIL %s lane %0d actual=%h expected=%h", tag, i,
                             act[i*EW +: EW], exp[i*EW +: EW]);
                    break;
                end
            end
        end
    endtask

    // Drive one operation at a falling edge; return at the next falling edge.
    task automatic issue(logic [1:0] op, logic [31:0] idx, logic [31:0] data, logic valid);
        op_valid      = valid;
        op_code       = op;
        lane_idx_word = idx;
        scalar_data   = data;
        if (valid && op == 2'b10) model[idx[5:0]] = data;
        @(negedge clk);
        op_valid = 1'b0;
        op_code  = 2'b11;
    endtask

    task automatic read_check(string tag, logic [31:0] idx);
        issue(2'b01, idx, 32'h0, 1'b1);
        chk32({tag, " valid"}, {31'd0, res_valid}, 32'd1);
        chk32(tag, scalar_res, model[idx[5:0]]);
    endtask

    task automatic sel_check(string tag, logic expl, logic [LN-1:0] vm, logic [LN-1:0] pm);
        logic [VW-1:0] exp_v;
        logic [LN-1:0] m;
        mask_src_explicit = expl;
        vcc_mask          = vm;
        pair_mask         = pm;
        m = expl ? pm : vm;
        for (int i = 0; i < LN; i++) begin
            exp_v[i*EW +: EW] = m[i] ? vsrc_b[i*EW +: EW] : vsrc_a[i*EW +: EW];
        end
        issue(2'b00, 32'h0, 32'h0, 1'b1);
        chk32({tag, " valid"}, {31'd0, res_valid}, 32'd1);
        chkvec(tag, vector_res, exp_v);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < LN; i++) model[i] = '0;
    endtask

    // Watchdog: a hung run is reported as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [VW-1:0] held_v;
        logic [31:0]   held_s;
        op_valid = 1'b0; op_code = 2'b11; lane_idx_word = '0; scalar_data = '0;
        mask_src_explicit = 1'b0; vcc_mask = '0; pair_mask = '0;
        for (int i = 0; i < LN; i++) begin
            vsrc_a[i*EW +: EW] = 32'hA000_0000 | i;
            vsrc_b[i*EW +: EW] = 32'hB000_0000 | i;
        end
        @(negedge clk);
        do_reset();

        // R1: state right after reset
        chk32("R1 res_valid after reset", {31'd0, res_valid}, 32'd0);
        chk32("R1 scalar_res after reset", scalar_res, 32'd0);
        chkvec("R1 vector_res after reset", vector_res, '0);

        // R2 R3 R4 R7 R9: table walk of lane writes and reads
        for (int k = 0; k < 11; k++) begin
            logic [1:0]  op;
            logic [31:0] idx, dat, exp;
            {op, idx, dat, exp} = TBL[k];
            issue(op, idx, dat, 1'b1);
            if (op == 2'b01) begin
                chk32("R2 R3 R7 read valid", {31'd0, res_valid}, 32'd1);
                chk32("R2 R3 R7 read data", scalar_res, exp);
            end else begin
                chk32("R9 write gives no valid", {31'd0, res_valid}, 32'd0);
            end
        end

        // R4: sweep every lane against the model
        for (int i = 0; i < LN; i++) read_check("R4 lane sweep", 32'(i));

        // R5 R6: masked select patterns
        sel_check("R5 mask all zero", 1'b0, '0, '1);
        sel_check("R5 mask all ones", 1'b0, '1, '0);
        sel_check("R5 mask alternating", 1'b0, {32{2'b10}}, '0);
        sel_check("R5 mask end bits", 1'b0, {1'b1, 62'd0, 1'b1}, '0);
        sel_check("R6 implicit source", 1'b0, {16{4'h0, 4'hF}} >> 0, ~{16{4'h0, 4'hF}});
        sel_check("R6 explicit source", 1'b1, ~{16{4'h0, 4'hF}}, {16{4'h0, 4'hF}});

        // R9: lane write leaves both results alone
        held_v = vector_res;
        held_s = scalar_res;
        issue(2'b10, 32'h0000_0007, 32'h7777_0007, 1'b1);
        chk32("R9 write valid low", {31'd0, res_valid}, 32'd0);
        chk32("R9 write scalar held", scalar_res, held_s);
        chkvec("R9 write vector held", vector_res, held_v);

        // R8: no-op code and op_valid low change nothing
        issue(2'b11, 32'h0000_0007, 32'hDEAD_DEAD, 1'b1);
        chk32("R8 noop valid low", {31'd0, res_valid}, 32'd0);
        chk32("R8 noop scalar held", scalar_res, held_s);
        chkvec("R8 noop vector held", vector_res, held_v);
        issue(2'b10, 32'h0000_0007, 32'hBEEF_BEEF, 1'b0);
        chk32("R8 idle valid low", {31'd0, res_valid}, 32'd0);
        issue(2'b00, 32'h0, 32'h0, 1'b0);
        chkvec("R8 idle select vector held", vector_res, held_v);
        read_check("R8 lane 7 unchanged", 32'h0000_0007);

        // R1: reset in mid-run clears lanes and outputs
        do_reset();
        chk32("R1 res_valid after mid reset", {31'd0, res_valid}, 32'd0);
        chk32("R1 scalar_res after mid reset", scalar_res, 32'd0);
        chkvec("R1 vector_res after mid reset", vector_res, '0);
        read_check("R1 lane 0 cleared", 32'd0);
        read_check("R1 lane 5 cleared", 32'd5);
        read_check("R1 lane 31 cleared", 32'd31);
        read_check("R1 lane 63 cleared", 32'd63);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule